// File: doc/BRIEF.md
# Execution-Unit Reservation Scoreboard

This block does the issue-timing bookkeeping for a simple in-order core. Each cycle it looks at no more than one request. A request names two candidate execution units, an issue latency, a completion latency, up to two source condition fields and one destination field. The block accepts the request only when three things hold: no source field is still being written, one of the two candidate units can take new work, and a tracking slot is free.

An accepted request opens a reservation with two countdowns. When the shorter one (issue) expires, the unit becomes free for pipelined reuse. When the longer one (completion) expires, the destination field is released and the slot goes back to the pool. A reservation that expires on the same edge as a new claim hands its unit, field or slot straight to the new request, so back-to-back use loses no cycle.

Free-running statistics count cycles, data-hazard waits, unit waits and per-unit grants. The block models timing only: no operand value passes through it.

Top module: `sb_scoreboard`

## Requirements
- R1: A synchronous reset clears every busy flag, pending flag, reservation slot and statistics counter, and leaves `reqReady` high with nothing outstanding.
- R2: If the first candidate unit can take work, it is granted. Otherwise the second candidate is granted. `grantUnit` shows the chosen unit during the cycle the request is accepted (`reqValid` and `reqReady` both high at a rising edge).
- R3: A source field is given as a 32-bit one-hot mask in which bit 31-n selects field n. An all-zero mask means no source. While any named source field is pending, `reqReady` is low and `dataStallCount` rises once per cycle with `reqValid` high.
- R4: While sources are clear but neither candidate unit (nor any slot) is available, `reqReady` is low. `unitStallCount` rises for every such waiting cycle of a request except its first.
- R5: A unit granted at edge k with issue latency I shows in `busyUnits` from edge k. A new request can be accepted on it at edge k+I, or at edge k+D if the completion latency D is shorter.
- R6: The destination of a request accepted at edge k with completion latency D shows in `pendingRegs` from edge k. A request that reads that field is accepted no earlier than edge k+D.
- R7: When one reservation releases a field on the same edge that a newer accepted reservation holds it, the field stays pending.
- R8: Each unit has a usage counter that rises by one for every grant to that unit.
- R9: `cycleCount` rises by one on every clock edge outside reset.
- R10: All statistics counters are STAT_W bits wide and stick at their all-ones value.
- R11: The pool holds ENTRIES reservations. When every slot is live and none expires at the coming edge, the request waits, and the wait is counted as a unit wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | A request is presented |
| reqUnitA | input | UW | Preferred candidate unit |
| reqUnitB | input | UW | Fallback candidate unit |
| reqIssueLat | input | LAT_W | Cycles before the unit accepts new work |
| reqDoneLat | input | LAT_W | Cycles before the destination is released |
| reqSrcMaskA | input | REGS | First source field, one-hot from the MSB |
| reqSrcMaskB | input | REGS | Second source field, one-hot from the MSB |
| reqDest | input | RW | Destination field index |
| reqReady | output | 1 | The request would be accepted at the next edge |
| grantUnit | output | UW | Unit chosen for the presented request |
| busyUnits | output | UNITS | Units holding a live issue reservation |
| pendingRegs | output | REGS | Fields awaiting completion |
| cycleCount | output | STAT_W | Cycles since reset |
| dataStallCount | output | STAT_W | Cycles spent waiting on sources |
| unitStallCount | output | STAT_W | Unit or slot waits beyond the first |
| unitUseCount | output | UNITS*STAT_W | Per-unit grant counts, unit u at bits u*STAT_W |

## Verification
Two things can land on the same edge. An expiring reservation can hand back its unit, field or slot while a new request claims that same resource. A newer claim can also land on a field that an older reservation is releasing. The bench causes the first by issuing requests back to back with issue latency 1 on one unit, with a dependent read timed to a completion, and with a ninth request waiting on a full pool. It judges the result by the exact number of wait cycles before acceptance. It causes the second with two writers to one field spaced one cycle apart, and checks that `pendingRegs` stays set across the older writer's release edge and clears only after the newer one completes.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // Strobes from control to datapath for the current cycle
  typedef struct packed {
    logic alloc;     // request accepted at this edge
    logic pickB;     // grant goes to the fallback candidate
    logic bumpData;  // count a source-hazard wait
    logic bumpUnit;  // count a unit/slot wait beyond the first
  } sbStrobe_t;
endpackage

// File: rtl/sb_control.sv
module sb_control
  import sb_pkg::*;
#(
  parameter int UNITS = 4,
  parameter int REGS  = 32,
  localparam int UW = $clog2(UNITS),
  localparam int RW = $clog2(REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic [UW-1:0]    reqUnitA,
  input  logic [UW-1:0]    reqUnitB,
  input  logic [REGS-1:0]  reqSrcMaskA,
  input  logic [REGS-1:0]  reqSrcMaskB,
  input  logic [UNITS-1:0] unitBusyEff,
  input  logic [REGS-1:0]  regPendEff,
  input  logic             entryAvail,
  output logic             reqReady,
  output sbStrobe_t        ctl
);
  // Leading-zero count from the MSB gives the field index
  function automatic logic [RW-1:0] maskToIdx(input logic [REGS-1:0] m);
    maskToIdx = '0;
    for (int i = 0; i < REGS; i++)
      if (m[i]) maskToIdx = RW'(REGS - 1 - i);
  endfunction

  logic [RW-1:0] idxA, idxB;
  logic srcHitA, srcHitB, dataHold, aFree, bFree, unitHold, waited;

  always_comb begin
    idxA     = maskToIdx(reqSrcMaskA);
    idxB     = maskToIdx(reqSrcMaskB);
    srcHitA  = (|reqSrcMaskA) && regPendEff[idxA];
    srcHitB  = (|reqSrcMaskB) && regPendEff[idxB];
    dataHold = srcHitA || srcHitB;
    aFree    = !unitBusyEff[reqUnitA];
    bFree    = !unitBusyEff[reqUnitB];
    unitHold = !(aFree || bFree) || !entryAvail;
    reqReady = !dataHold && !unitHold;

    ctl.alloc    = reqValid && reqReady;
    ctl.pickB    = !aFree;
    ctl.bumpData = reqValid && dataHold;
    ctl.bumpUnit = reqValid && !dataHold && unitHold && waited;
  end

  // Remembers that the previous cycle was already a unit wait
  always_ff @(posedge clk) begin
    if (rst) waited <= 1'b0;
    else     waited <= reqValid && !dataHold && unitHold;
  end
endmodule

// File: rtl/sb_datapath.sv
module sb_datapath
  import sb_pkg::*;
#(
  parameter int UNITS   = 4,
  parameter int ENTRIES = 8,
  parameter int REGS    = 32,
  parameter int LAT_W   = 4,
  parameter int STAT_W  = 32,
  localparam int UW = $clog2(UNITS),
  localparam int EW = $clog2(ENTRIES),
  localparam int RW = $clog2(REGS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  sbStrobe_t               ctl,
  input  logic [UW-1:0]           reqUnitA,
  input  logic [UW-1:0]           reqUnitB,
  input  logic [LAT_W-1:0]        reqIssueLat,
  input  logic [LAT_W-1:0]        reqDoneLat,
  input  logic [RW-1:0]           reqDest,
  output logic [UNITS-1:0]        unitBusyEff,
  output logic [REGS-1:0]         regPendEff,
  output logic                    entryAvail,
  output logic [UW-1:0]           grantUnit,
  output logic [UNITS-1:0]        busyUnits,
  output logic [REGS-1:0]         pendingRegs,
  output logic [STAT_W-1:0]       cycleCount,
  output logic [STAT_W-1:0]       dataStallCount,
  output logic [STAT_W-1:0]       unitStallCount,
  output logic [UNITS*STAT_W-1:0] unitUseCount
);
  localparam logic [STAT_W-1:0] SAT = {STAT_W{1'b1}};

  logic [ENTRIES-1:0] eActive, eHold;
  logic [UW-1:0]      eUnit  [ENTRIES];
  logic [RW-1:0]      eDest  [ENTRIES];
  logic [LAT_W-1:0]   eIssue [ENTRIES];
  logic [LAT_W-1:0]   eDone  [ENTRIES];
  logic [ENTRIES-1:0] endAll, endUnit, slotFree;
  logic [EW-1:0]      allocSlot;
  logic [STAT_W-1:0]  useCnt [UNITS];

  // Per-slot expiry at the coming edge; latency 0 behaves like 1
  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      endAll[e]   = eDone[e] <= LAT_W'(1);
      endUnit[e]  = endAll[e] || (eIssue[e] <= LAT_W'(1));
      slotFree[e] = !eActive[e] || endAll[e];
    end
  end

  // Flags as stored, and as seen by a request after this edge's expiries
  always_comb begin
    busyUnits   = '0;
    unitBusyEff = '0;
    pendingRegs = '0;
    regPendEff  = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (eActive[e]) begin
        if (eHold[e]) begin
          busyUnits[eUnit[e]] = 1'b1;
          if (!endUnit[e]) unitBusyEff[eUnit[e]] = 1'b1;
        end
        pendingRegs[eDest[e]] = 1'b1;
        if (!endAll[e]) regPendEff[eDest[e]] = 1'b1;
      end
    end
  end

  always_comb begin
    allocSlot = '0;
    for (int e = ENTRIES - 1; e >= 0; e--)
      if (slotFree[e]) allocSlot = EW'(e);
    entryAvail = |slotFree;
    grantUnit  = ctl.pickB ? reqUnitB : reqUnitA;
  end

  // Countdowns; an allocation overrides an expiring slot
  always_ff @(posedge clk) begin
    if (rst) begin
      eActive <= '0;
      eHold   <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (eActive[e]) begin
          if (endAll[e]) begin
            eActive[e] <= 1'b0;
            eHold[e]   <= 1'b0;
          end else begin
            eDone[e] <= eDone[e] - 1'b1;
            if (endUnit[e]) eHold[e]  <= 1'b0;
            else            eIssue[e] <= eIssue[e] - 1'b1;
          end
        end
      end
      if (ctl.alloc) begin
        eActive[allocSlot] <= 1'b1;
        eHold[allocSlot]   <= 1'b1;
        eUnit[allocSlot]   <= grantUnit;
        eDest[allocSlot]   <= reqDest;
        eIssue[allocSlot]  <= reqIssueLat;
        eDone[allocSlot]   <= reqDoneLat;
      end
    end
  end

  // Saturating statistics
  always_ff @(posedge clk) begin
    if (rst) begin
      cycleCount     <= '0;
      dataStallCount <= '0;
      unitStallCount <= '0;
      for (int u = 0; u < UNITS; u++) useCnt[u] <= '0;
    end else begin
      if (cycleCount != SAT) cycleCount <= cycleCount + 1'b1;
      if (ctl.bumpData && dataStallCount != SAT) dataStallCount <= dataStallCount + 1'b1;
      if (ctl.bumpUnit && unitStallCount != SAT) unitStallCount <= unitStallCount + 1'b1;
      if (ctl.alloc && useCnt[grantUnit] != SAT) useCnt[grantUnit] <= useCnt[grantUnit] + 1'b1;
    end
  end

  for (genvar u = 0; u < UNITS; u++) begin : g_use
    assign unitUseCount[u*STAT_W +: STAT_W] = useCnt[u];
  end
endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard
  import sb_pkg::*;
#(
  parameter int UNITS   = 4,
  parameter int ENTRIES = 8,
  parameter int REGS    = 32,
  parameter int LAT_W   = 4,
  parameter int STAT_W  = 32,
  localparam int UW = $clog2(UNITS),
  localparam int RW = $clog2(REGS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reqValid,
  input  logic [UW-1:0]           reqUnitA,
  input  logic [UW-1:0]           reqUnitB,
  input  logic [LAT_W-1:0]        reqIssueLat,
  input  logic [LAT_W-1:0]        reqDoneLat,
  input  logic [REGS-1:0]         reqSrcMaskA,
  input  logic [REGS-1:0]         reqSrcMaskB,
  input  logic [RW-1:0]           reqDest,
  output logic                    reqReady,
  output logic [UW-1:0]           grantUnit,
  output logic [UNITS-1:0]        busyUnits,
  output logic [REGS-1:0]         pendingRegs,
  output logic [STAT_W-1:0]       cycleCount,
  output logic [STAT_W-1:0]       dataStallCount,
  output logic [STAT_W-1:0]       unitStallCount,
  output logic [UNITS*STAT_W-1:0] unitUseCount
);
  sbStrobe_t        ctl;
  logic [UNITS-1:0] unitBusyEff;
  logic [REGS-1:0]  regPendEff;
  logic             entryAvail;

  sb_control #(.UNITS(UNITS), .REGS(REGS)) u_ctl (
    .clk(clk), .rst(rst), .reqValid(reqValid),
    .reqUnitA(reqUnitA), .reqUnitB(reqUnitB),
    .reqSrcMaskA(reqSrcMaskA), .reqSrcMaskB(reqSrcMaskB),
    .unitBusyEff(unitBusyEff), .regPendEff(regPendEff), .entryAvail(entryAvail),
    .reqReady(reqReady), .ctl(ctl)
  );

  sb_datapath #(.UNITS(UNITS), .ENTRIES(ENTRIES), .REGS(REGS),
                .LAT_W(LAT_W), .STAT_W(STAT_W)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .reqUnitA(reqUnitA), .reqUnitB(reqUnitB),
    .reqIssueLat(reqIssueLat), .reqDoneLat(reqDoneLat), .reqDest(reqDest),
    .unitBusyEff(unitBusyEff), .regPendEff(regPendEff), .entryAvail(entryAvail),
    .grantUnit(grantUnit), .busyUnits(busyUnits), .pendingRegs(pendingRegs),
    .cycleCount(cycleCount), .dataStallCount(dataStallCount),
    .unitStallCount(unitStallCount), .unitUseCount(unitUseCount)
  );
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int UNITS  = 4,
  parameter int REGS   = 32,
  parameter int STAT_W = 32,
  localparam int UW = $clog2(UNITS),
  localparam int RW = $clog2(REGS)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    reqValid,
  input logic                    reqReady,
  input logic [UW-1:0]           reqUnitA,
  input logic [UW-1:0]           reqUnitB,
  input logic [RW-1:0]           reqDest,
  input logic [UW-1:0]           grantUnit,
  input logic [UNITS-1:0]        busyUnits,
  input logic [REGS-1:0]         pendingRegs,
  input logic [STAT_W-1:0]       cycleCount,
  input logic [STAT_W-1:0]       dataStallCount,
  input logic [STAT_W-1:0]       unitStallCount,
  input logic [UNITS*STAT_W-1:0] unitUseCount
);
  logic              accept;
  logic [STAT_W-1:0] grantCnt;
  assign accept   = reqValid && reqReady;
  assign grantCnt = unitUseCount[grantUnit*STAT_W +: STAT_W];

  p_pref_first_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && !busyUnits[reqUnitA]) |-> grantUnit == reqUnitA);

  p_grant_candidate_r2: assert property (@(posedge clk) disable iff (rst)
    accept |-> (grantUnit == reqUnitA || grantUnit == reqUnitB));

  p_busy_after_grant_r5: assert property (@(posedge clk) disable iff (rst)
    accept |=> busyUnits[$past(grantUnit)]);

  p_dest_pending_r6: assert property (@(posedge clk) disable iff (rst)
    accept |=> pendingRegs[$past(reqDest)]);

  p_use_count_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && grantCnt != {STAT_W{1'b1}}) |=>
      unitUseCount[$past(grantUnit)*STAT_W +: STAT_W] == STAT_W'($past(grantCnt) + 1'b1));

  p_cycle_step_r9: assert property (@(posedge clk) disable iff (rst)
    (cycleCount != {STAT_W{1'b1}}) |=> cycleCount == STAT_W'($past(cycleCount) + 1'b1));

  p_stall_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> !((dataStallCount != $past(dataStallCount)) &&
               (unitStallCount != $past(unitStallCount))));
endmodule

bind sb_scoreboard sb_checker #(.UNITS(UNITS), .REGS(REGS), .STAT_W(STAT_W)) u_chk (.*);

// File: tb/sim_sb_scoreboard.sv
`timescale 1ns/1ps
module sim_sb_scoreboard;
  localparam int UNITS = 4, REGS = 32, LAT_W = 4, SW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic [1:0] reqUnitA = '0, reqUnitB = '0;
  logic [LAT_W-1:0] reqIssueLat = '0, reqDoneLat = '0;
  logic [REGS-1:0] reqSrcMaskA = '0, reqSrcMaskB = '0;
  logic [4:0] reqDest = '0;
  logic reqReady;
  logic [1:0] grantUnit;
  logic [UNITS-1:0] busyUnits;
  logic [REGS-1:0] pendingRegs;
  logic [SW-1:0] cycleCount, dataStallCount, unitStallCount;
  logic [UNITS*SW-1:0] unitUseCount;

  // Narrow-counter instance for saturation
  logic sReady;
  logic [1:0] sGrant;
  logic [UNITS-1:0] sBusy;
  logic [REGS-1:0] sPend;
  logic [3:0] sCyc, sData, sUnit;
  logic [UNITS*4-1:0] sUse;

  int errors = 0, checks = 0, edges = 0;
  int expUse [UNITS];
  int expQ [$];

  always #4 clk = ~clk;

  sb_scoreboard u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqUnitA(reqUnitA), .reqUnitB(reqUnitB),
    .reqIssueLat(reqIssueLat), .reqDoneLat(reqDoneLat),
    .reqSrcMaskA(reqSrcMaskA), .reqSrcMaskB(reqSrcMaskB), .reqDest(reqDest),
    .reqReady(reqReady), .grantUnit(grantUnit), .busyUnits(busyUnits),
    .pendingRegs(pendingRegs), .cycleCount(cycleCount), .dataStallCount(dataStallCount),
    .unitStallCount(unitStallCount), .unitUseCount(unitUseCount));

  sb_scoreboard #(.STAT_W(4)) u1 (
    .clk(clk), .rst(rst), .reqValid(1'b0), .reqUnitA(2'd0), .reqUnitB(2'd0),
    .reqIssueLat(4'd1), .reqDoneLat(4'd1), .reqSrcMaskA('0), .reqSrcMaskB('0),
    .reqDest(5'd0), .reqReady(sReady), .grantUnit(sGrant), .busyUnits(sBusy),
    .pendingRegs(sPend), .cycleCount(sCyc), .dataStallCount(sData),
    .unitStallCount(sUnit), .unitUseCount(sUse));

  always @(posedge clk) begin
    if (rst) edges = 0;
    else     edges = edges + 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [REGS-1:0] fieldMask(input int f);
    return (f < 0) ? '0 : (32'h1 << (31 - f));
  endfunction

  // Monitor: pops the expected grant whenever an acceptance is due
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!rst && reqValid && reqReady) begin
        if (expQ.size() == 0) chk(1'b0, "R2 unexpected accept", grantUnit, -1);
        else begin
          int e;
          e = expQ.pop_front();
          chk(grantUnit == 2'(e), "R2 grant unit", grantUnit, e);
        end
      end
    end
  end

  // Driver: called at a falling edge, returns at the falling edge after acceptance
  task automatic issue(input int ua, input int ub, input int il, input int dl, input int dst,
                       input int sa, input int sb, input int eu, output int waits);
    reqUnitA = 2'(ua); reqUnitB = 2'(ub);
    reqIssueLat = LAT_W'(il); reqDoneLat = LAT_W'(dl);
    reqDest = 5'(dst);
    reqSrcMaskA = fieldMask(sa); reqSrcMaskB = fieldMask(sb);
    reqValid = 1'b1;
    expQ.push_back(eu);
    expUse[eu]++;
    waits = 0;
    forever begin
      #2;
      if (reqReady) break;
      waits++;
      @(negedge clk);
    end
    @(negedge clk);
    reqValid = 1'b0;
    reqSrcMaskA = '0; reqSrcMaskB = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w;
    longint d0, u0c;
    for (int u = 0; u < UNITS; u++) expUse[u] = 0;
    idle(3);
    rst = 1'b0;
    #2;
    // R1 reset state
    chk(busyUnits == 0 && pendingRegs == 0, "R1 flags clear", {busyUnits, pendingRegs}, 0);
    chk(cycleCount == 0 && dataStallCount == 0 && unitStallCount == 0 && unitUseCount == 0,
        "R1 counters clear", cycleCount, 0);
    chk(reqReady == 1'b1, "R1 ready", reqReady, 1);
    @(negedge clk);

    // R2 preference, R5 pipelined reuse at edge k+I
    issue(1, 2, 2, 3, 3, -1, -1, 1, w); chk(w == 0, "R2 first free", w, 0);
    issue(1, 2, 2, 3, 3, -1, -1, 2, w); chk(w == 0, "R2 fallback", w, 0);
    issue(1, 2, 2, 3, 3, -1, -1, 1, w); chk(w == 0, "R5 reuse after issue latency", w, 0);
    idle(20);

    // R4 unit waits beyond the first; R5 release at k+I
    d0 = dataStallCount; u0c = unitStallCount;
    issue(0, 0, 3, 3, 1, -1, -1, 0, w);
    issue(0, 0, 1, 1, 2, -1, -1, 0, w); chk(w == 2, "R5 unit held for issue latency", w, 2);
    idle(5);
    chk(unitStallCount - u0c == 1, "R4 unit stall count", unitStallCount - u0c, 1);
    chk(dataStallCount == d0, "R4 no data stall", dataStallCount - d0, 0);

    // R3/R6 source hazard through mask A, then mask B
    d0 = dataStallCount; u0c = unitStallCount;
    issue(1, 1, 1, 4, 5, -1, -1, 1, w);
    issue(2, 2, 1, 1, 6, 5, -1, 2, w); chk(w == 3, "R6 dependent waits for completion", w, 3);
    idle(5);
    chk(dataStallCount - d0 == 3, "R3 data stall count", dataStallCount - d0, 3);
    chk(unitStallCount == u0c, "R3 no unit stall", unitStallCount - u0c, 0);
    issue(1, 1, 1, 2, 9, -1, -1, 1, w);
    issue(2, 2, 1, 1, 10, -1, 9, 2, w); chk(w == 1, "R3 second source mask", w, 1);
    idle(5);

    // R5/R6 flag timeline: I=2, D=3
    issue(3, 3, 2, 3, 7, -1, -1, 3, w);
    #2;
    chk(busyUnits[3] && pendingRegs[7], "R5 busy and pending after grant", {busyUnits[3], pendingRegs[7]}, 3);
    @(negedge clk); #2;
    chk(busyUnits[3] && pendingRegs[7], "R5 still held", {busyUnits[3], pendingRegs[7]}, 3);
    @(negedge clk); #2;
    chk(!busyUnits[3] && pendingRegs[7], "R5 unit freed at issue latency", {busyUnits[3], pendingRegs[7]}, 1);
    @(negedge clk); #2;
    chk(pendingRegs[7] == 1'b0, "R6 field released at completion", pendingRegs[7], 0);
    idle(3);

    // R7 release of an older writer while a newer one holds the field
    issue(0, 0, 1, 2, 4, -1, -1, 0, w);
    issue(1, 1, 1, 3, 4, -1, -1, 1, w);
    #2;
    chk(pendingRegs[4] == 1'b1, "R7 pending after second writer", pendingRegs[4], 1);
    @(negedge clk); #2;
    chk(pendingRegs[4] == 1'b1, "R7 kept over release", pendingRegs[4], 1);
    @(negedge clk); @(negedge clk); #2;
    chk(pendingRegs[4] == 1'b0, "R7 clears after newer completes", pendingRegs[4], 0);
    idle(5);

    // R8 usage counters, R9 cycle counter
    #2;
    for (int u = 0; u < UNITS; u++)
      chk(unitUseCount[u*SW +: SW] == SW'(expUse[u]), "R8 unit usage", unitUseCount[u*SW +: SW], expUse[u]);
    chk(cycleCount == SW'(edges), "R9 cycle count", cycleCount, edges);
    @(negedge clk);

    // R11 pool of 8 slots filled with long completions
    u0c = unitStallCount;
    for (int i = 0; i < 8; i++) issue(3, 3, 1, 15, 20 + i, -1, -1, 3, w);
    issue(3, 3, 1, 1, 30, -1, -1, 3, w);
    chk(w == 7, "R11 waits for a free slot", w, 7);
    idle(2);
    chk(unitStallCount - u0c == 6, "R11 slot wait counted as unit wait", unitStallCount - u0c, 6);

    // R1 mid-run reset with reservations outstanding
    issue(2, 2, 5, 15, 11, -1, -1, 2, w);
    rst = 1'b1;
    @(negedge clk); #2;
    chk(busyUnits == 0 && pendingRegs == 0, "R1 reset clears live reservations", {busyUnits, pendingRegs}, 0);
    chk(cycleCount == 0 && unitUseCount == 0, "R1 reset clears counters", cycleCount, 0);
    @(negedge clk);
    rst = 1'b0;
    idle(20);
    #2;
    // R10 narrow counter sticks at all ones
    chk(sCyc == 4'hF, "R10 saturation", sCyc, 15);
    chk(cycleCount == SW'(edges), "R9 count after reset", cycleCount, edges);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule